// File: doc/BRIEF.md
# Two-Run Interleaved Annealing Scheduler

This block arbitrates one shared matrix-vector engine and one shared neuron update unit between two independent annealing runs of the same problem. Both runs use the same weights and bias, so nothing in the engine is rewritten between them. Only the starting state differs. The scheduler does no arithmetic itself. It drives the seeding logic, the engine and the update unit through request and acknowledge signals. It tracks the phase, iteration count, stability count and completion of each run on its own.

After `start`, run 0 is seeded and its output vector goes to the engine. Once run 0's product has come back, run 1 is seeded. The update unit then works on run 0's product while the engine computes run 1's product. In steady state the engine alternates strictly between the runs. When one run finishes, the other carries on alone. A run ends when its outputs have held steady for `STABLE_LEN` consecutive updates, or when it reaches `MAX_ITER` updates.

Sequencer states and transitions:
- `S_IDLE` goes to `S_SEED_A` on `start`.
- `S_SEED_A` goes to `S_WAIT_A` on `seed_ack`.
- `S_WAIT_A` goes to `S_SEED_B` when run 0's product is valid.
- `S_SEED_B` goes to `S_RUN` on `seed_ack`.
- `S_RUN` goes to `S_IDLE` when both runs are done.

Per-run phases:
- `PH_IDLE` or `PH_DONE` goes to `PH_SEED` on start.
- `PH_SEED` goes to `PH_READY` on seeded.
- `PH_READY` goes to `PH_MVM` on issue.
- `PH_MVM` goes to `PH_HELD` when its result returns.
- `PH_MVM` or `PH_HELD` goes to `PH_UPD` when the result is taken.
- `PH_UPD` goes to `PH_READY` on update done, or to `PH_DONE` if a stop condition is met.

Top module: `dual_run_sched`

## Requirements
- R1: While reset is held low, and right after it is released, `active`, `seed_req`, `mvm_go`, `mvm_ack` and `upd_go` are low, `run_done` and `run_conv` are 2'b00, and both iteration counts are zero. Reset applied in the middle of a run returns the block to this state.
- R2: A `start` while idle raises `seed_req` with `seed_run`=0 (run 0) first. `seed_req` with `seed_run`=1 is raised only after run 0's first product has been reported valid.
- R3: `mvm_go` is raised only while `mvm_busy` and `mvm_valid` are both low and the previous result has been taken, so at most one vector is ever outstanding in the engine.
- R4: A result is taken (`mvm_ack`) in exactly the cycle the update unit is started (`upd_go`), with `upd_run` naming the run that owns the result. No new update starts before the previous one reports `upd_done`.
- R5: While both runs are live, successive `mvm_go` issues alternate between run 0 and run 1. A finished run is never issued, and the remaining run is then issued back to back.
- R6: Each `upd_done` adds one to that run's iteration count. An update with `upd_flip`=1 clears the run's stability count, and one with `upd_flip`=0 increments it.
- R7: A run becomes done with `run_conv` set when its stability count reaches `STABLE_LEN`. It becomes done with `run_conv` clear when its iteration count reaches `MAX_ITER` first. When both happen on the same update, `run_conv` is set.
- R8: A run's done flag, converged flag and iteration count hold until the next accepted `start`. `active` falls once both runs are done.
- R9: A `start` pulse while `active` is high is ignored: no new seed request is made and the results are unaffected.
- R10: The update unit processes one run's product while the engine is busy with, or holding, the other run's product.
- R11: Run 0's iteration count occupies `run_iter[ITER_W-1:0]` and run 1's occupies `run_iter[2*ITER_W-1:ITER_W]`. Bit 0 of `run_done` and `run_conv` belongs to run 0, and bit 1 to run 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin both runs (honoured only while idle) |
| active | output | 1 | High from an accepted start until both runs are done |
| seed_req | output | 1 | Request to load a run's initial state and compute its first output |
| seed_run | output | 1 | Run addressed by `seed_req` |
| seed_ack | input | 1 | One-cycle pulse: seeding finished |
| mvm_go | output | 1 | Issue the selected run's output vector to the engine |
| mvm_run | output | 1 | Run whose vector is issued |
| mvm_busy | input | 1 | Engine is computing |
| mvm_valid | input | 1 | Engine holds a finished product, held until taken |
| mvm_ack | output | 1 | Product taken from the engine |
| upd_go | output | 1 | Start the update unit on the taken product |
| upd_run | output | 1 | Run being updated |
| upd_done | input | 1 | One-cycle pulse: update finished |
| upd_flip | input | 1 | With `upd_done`: at least one output top bit changed |
| run_done | output | 2 | Per-run completion flag |
| run_conv | output | 2 | Per-run converged flag (clear if stopped by the limit) |
| run_iter | output | 2*ITER_W | Per-run iteration counts |

## Verification
A table drives pairs of settling points: the number of leading updates in each run that report a flipped output. The pairs cover the following cases:
- Both runs settling at once.
- One run finishing long before the other, which exposes whether the survivor is issued alone.
- A run settling on exactly its last permitted update, which checks that convergence takes priority over the limit.
- Runs that never settle, which checks the limit stop.

Throughout the bench, monitors watch the following:
- The engine and update handshakes.
- The seeding order.
- Strict alternation.
- Whether one run's update really overlaps the other run's product.

Directed cases cover the reset state, a start pulse in the middle of a run, and reset in the middle of a run.

// File: rtl/dual_run_sched_pkg.sv
`timescale 1ns/1ps
package dual_run_sched_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEED,
        PH_READY,
        PH_MVM,
        PH_HELD,
        PH_UPD,
        PH_DONE
    } run_phase_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEED_A,
        S_WAIT_A,
        S_SEED_B,
        S_RUN
    } seq_state_t;

    localparam int NUM_RUNS = 2;

endpackage

// File: rtl/run_tracker.sv
`timescale 1ns/1ps
module run_tracker
    import dual_run_sched_pkg::*;
#(
    parameter int MAX_ITER   = 1000,
    parameter int STABLE_LEN = 10,
    parameter int ITER_W     = $clog2(MAX_ITER + 1),
    parameter int STAB_W     = $clog2(STABLE_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_seeded,
    input  logic              ev_issue,
    input  logic              ev_result,
    input  logic              ev_take,
    input  logic              ev_upd_done,
    input  logic              upd_flip,
    output run_phase_t        phase,
    output logic [ITER_W-1:0] iter_cnt,
    output logic              done,
    output logic              conv
);

    run_phase_t        phase_q, phase_nx;
    logic [ITER_W-1:0] iter_q;
    logic [STAB_W-1:0] stab_q;
    logic              conv_q;
    logic              hit_stab, hit_cap, restart, finishing;

    always_comb begin
        hit_stab  = !upd_flip && (stab_q == STAB_W'(STABLE_LEN - 1));
        hit_cap   = (iter_q == ITER_W'(MAX_ITER - 1));
        restart   = ev_start && (phase_q == PH_IDLE || phase_q == PH_DONE);
        finishing = ev_upd_done && (phase_q == PH_UPD);
    end

    always_comb begin
        phase_nx = phase_q;
        unique case (phase_q)
            PH_IDLE, PH_DONE: if (ev_start)    phase_nx = PH_SEED;
            PH_SEED:          if (ev_seeded)   phase_nx = PH_READY;
            PH_READY:         if (ev_issue)    phase_nx = PH_MVM;
            PH_MVM: begin
                if (ev_take)        phase_nx = PH_UPD;
                else if (ev_result) phase_nx = PH_HELD;
            end
            PH_HELD:          if (ev_take)     phase_nx = PH_UPD;
            PH_UPD: begin
                if (ev_upd_done)
                    phase_nx = (hit_stab || hit_cap) ? PH_DONE : PH_READY;
            end
            default:          phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            iter_q <= '0;
            stab_q <= '0;
            conv_q <= 1'b0;
        end else if (finishing) begin
            iter_q <= iter_q + 1'b1;
            stab_q <= upd_flip ? '0 : stab_q + 1'b1;
            if (hit_stab) conv_q <= 1'b1;
        end
    end

    always_comb begin
        phase    = phase_q;
        iter_cnt = iter_q;
        done     = (phase_q == PH_DONE);
        conv     = conv_q;
    end

    AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= ITER_W'(MAX_ITER)); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) && !ev_start |=> (phase_q == PH_DONE)); // R8
    AST_ITER_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_upd_done && !ev_start |=> $stable(iter_q)); // R6
    AST_STAB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stab_q <= STAB_W'(STABLE_LEN)); // R7

endmodule

// File: rtl/sched_ctrl.sv
`timescale 1ns/1ps
module sched_ctrl
    import dual_run_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       seed_ack,
    input  logic       mvm_busy,
    input  logic       mvm_valid,
    input  logic       upd_done,
    input  run_phase_t ph0,
    input  run_phase_t ph1,
    output logic       active,
    output logic       seed_req,
    output logic       seed_run,
    output logic       mvm_go,
    output logic       mvm_run,
    output logic       mvm_ack,
    output logic       upd_go,
    output logic       upd_run,
    output logic [1:0] ev_start,
    output logic [1:0] ev_seeded,
    output logic [1:0] ev_issue,
    output logic [1:0] ev_result,
    output logic [1:0] ev_take,
    output logic [1:0] ev_upd_done
);

    seq_state_t state, state_nx;
    logic       eng_out, eng_owner, upd_busy, upd_owner, last_run;
    logic [1:0] rdy, fin, may_issue;
    logic       pick, take, eng_free, result_here;

    // arbitration terms
    always_comb begin
        rdy          = {ph1 == PH_READY, ph0 == PH_READY};
        fin          = {ph1 == PH_DONE,  ph0 == PH_DONE};
        may_issue[0] = rdy[0] && (last_run || fin[1]);
        may_issue[1] = rdy[1] && (!last_run || fin[0]);
        eng_free     = !eng_out && !mvm_busy && !mvm_valid;
        pick         = !may_issue[0];
        result_here  = mvm_valid && eng_out;
        take         = result_here && !upd_busy;
    end

    // next sequencer state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start)                      state_nx = S_SEED_A;
            S_SEED_A: if (seed_ack)                   state_nx = S_WAIT_A;
            S_WAIT_A: if (result_here && !eng_owner)  state_nx = S_SEED_B;
            S_SEED_B: if (seed_ack)                   state_nx = S_RUN;
            S_RUN:    if (fin == 2'b11)               state_nx = S_IDLE;
            default:                                  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs and per-run events
    always_comb begin
        active      = (state != S_IDLE);
        seed_req    = (state == S_SEED_A) || (state == S_SEED_B);
        seed_run    = (state == S_SEED_B);
        mvm_go      = active && eng_free && (|may_issue);
        mvm_run     = pick;
        mvm_ack     = take;
        upd_go      = take;
        upd_run     = eng_owner;
        ev_start    = {2{(state == S_IDLE) && start}};
        ev_seeded   = {seed_ack && (state == S_SEED_B), seed_ack && (state == S_SEED_A)};
        ev_issue    = mvm_go ? (pick ? 2'b10 : 2'b01) : 2'b00;
        ev_result   = {result_here && eng_owner, result_here && !eng_owner};
        ev_take     = {take && eng_owner, take && !eng_owner};
        ev_upd_done = {upd_done && upd_busy && upd_owner,
                       upd_done && upd_busy && !upd_owner};
    end

    // resource ownership
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_out   <= 1'b0;
            eng_owner <= 1'b0;
            upd_busy  <= 1'b0;
            upd_owner <= 1'b0;
            last_run  <= 1'b1;
        end else begin
            if (mvm_go) begin
                eng_out   <= 1'b1;
                eng_owner <= pick;
            end else if (take) begin
                eng_out   <= 1'b0;
            end
            if (take) begin
                upd_busy  <= 1'b1;
                upd_owner <= eng_owner;
            end else if (upd_done) begin
                upd_busy  <= 1'b0;
            end
            if (state == S_IDLE && start) last_run <= 1'b1;
            else if (mvm_go)              last_run <= pick;
        end
    end

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        mvm_valid && !mvm_ack |=> !mvm_go); // R3
    AST_ONE_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        upd_go |=> !upd_go); // R4
    AST_SEED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        seed_req && seed_run |-> (ph0 != PH_IDLE) && (ph0 != PH_SEED)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) && start |=> (state != S_SEED_A)); // R9
    AST_NO_GO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mvm_go |-> !((ph0 == PH_DONE) && !mvm_run) && !((ph1 == PH_DONE) && mvm_run)); // R5

endmodule

// File: rtl/dual_run_sched.sv
`timescale 1ns/1ps
module dual_run_sched
    import dual_run_sched_pkg::*;
#(
    parameter int MAX_ITER   = 1000,
    parameter int STABLE_LEN = 10,
    parameter int ITER_W     = $clog2(MAX_ITER + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         active,
    output logic                         seed_req,
    output logic                         seed_run,
    input  logic                         seed_ack,
    output logic                         mvm_go,
    output logic                         mvm_run,
    input  logic                         mvm_busy,
    input  logic                         mvm_valid,
    output logic                         mvm_ack,
    output logic                         upd_go,
    output logic                         upd_run,
    input  logic                         upd_done,
    input  logic                         upd_flip,
    output logic [NUM_RUNS-1:0]          run_done,
    output logic [NUM_RUNS-1:0]          run_conv,
    output logic [NUM_RUNS*ITER_W-1:0]   run_iter
);

    localparam int STAB_W = $clog2(STABLE_LEN + 1);

    run_phase_t ph [NUM_RUNS];
    logic [1:0] ev_start, ev_seeded, ev_issue, ev_result, ev_take, ev_upd_done;

    sched_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .seed_ack   (seed_ack),
        .mvm_busy   (mvm_busy),
        .mvm_valid  (mvm_valid),
        .upd_done   (upd_done),
        .ph0        (ph[0]),
        .ph1        (ph[1]),
        .active     (active),
        .seed_req   (seed_req),
        .seed_run   (seed_run),
        .mvm_go     (mvm_go),
        .mvm_run    (mvm_run),
        .mvm_ack    (mvm_ack),
        .upd_go     (upd_go),
        .upd_run    (upd_run),
        .ev_start   (ev_start),
        .ev_seeded  (ev_seeded),
        .ev_issue   (ev_issue),
        .ev_result  (ev_result),
        .ev_take    (ev_take),
        .ev_upd_done(ev_upd_done)
    );

    for (genvar g = 0; g < NUM_RUNS; g++) begin : g_run
        run_tracker #(
            .MAX_ITER  (MAX_ITER),
            .STABLE_LEN(STABLE_LEN),
            .ITER_W    (ITER_W),
            .STAB_W    (STAB_W)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_start   (ev_start[g]),
            .ev_seeded  (ev_seeded[g]),
            .ev_issue   (ev_issue[g]),
            .ev_result  (ev_result[g]),
            .ev_take    (ev_take[g]),
            .ev_upd_done(ev_upd_done[g]),
            .upd_flip   (upd_flip),
            .phase      (ph[g]),
            .iter_cnt   (run_iter[g*ITER_W +: ITER_W]),
            .done       (run_done[g]),
            .conv       (run_conv[g])
        );
    end

    AST_IDLE_WHEN_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
        active && (run_done == 2'b11) |=> !active); // R8

endmodule

// File: tb/tb_dual_run_sched.sv
`timescale 1ns/1ps
module tb_dual_run_sched;

    localparam int MAXI = 20;
    localparam int STBL = 4;
    localparam int IW   = $clog2(MAXI + 1);
    localparam int LAT_M = 5;
    localparam int LAT_U = 3;
    localparam int ROWS = 6;
    // per row: flipping updates of run0/run1, expected iterations and converged flags
    localparam int K0 [ROWS] = '{0, 3, 16, 30, 25, 1};
    localparam int K1 [ROWS] = '{0, 10, 2, 5, 25, 17};
    localparam int E0 [ROWS] = '{4, 7, 20, 20, 20, 5};
    localparam int C0 [ROWS] = '{1, 1, 1, 0, 0, 1};
    localparam int E1 [ROWS] = '{4, 14, 6, 9, 20, 20};
    localparam int C1 [ROWS] = '{1, 1, 1, 1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic active, seed_req, seed_run, seed_ack;
    logic mvm_go, mvm_run, mvm_busy, mvm_valid, mvm_ack;
    logic upd_go, upd_run, upd_done, upd_flip;
    logic [1:0] run_done, run_conv;
    logic [2*IW-1:0] run_iter;

    always #2.5 clk = ~clk;

    dual_run_sched #(.MAX_ITER(MAXI), .STABLE_LEN(STBL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .active(active),
        .seed_req(seed_req), .seed_run(seed_run), .seed_ack(seed_ack),
        .mvm_go(mvm_go), .mvm_run(mvm_run), .mvm_busy(mvm_busy),
        .mvm_valid(mvm_valid), .mvm_ack(mvm_ack), .upd_go(upd_go),
        .upd_run(upd_run), .upd_done(upd_done), .upd_flip(upd_flip),
        .run_done(run_done), .run_conv(run_conv), .run_iter(run_iter)
    );

    int errors = 0;
    int checks = 0;
    int k0 = 0, k1 = 0;
    logic row_clear = 1'b0;

    // seeding responder
    int scnt = 0;
    always @(posedge clk) begin
        if (!rst_n || !seed_req) begin
            seed_ack <= 1'b0; scnt <= 0;
        end else if (seed_ack) begin
            seed_ack <= 1'b0; scnt <= 0;
        end else if (scnt == 2) begin
            seed_ack <= 1'b1; scnt <= 0;
        end else begin
            scnt <= scnt + 1;
        end
    end

    // engine model
    int ecnt = 0;
    logic erun = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mvm_busy <= 1'b0; mvm_valid <= 1'b0; ecnt <= 0;
        end else begin
            if (mvm_go) begin
                mvm_busy <= 1'b1; ecnt <= LAT_M; erun <= mvm_run;
            end else if (mvm_busy) begin
                if (ecnt == 1) begin mvm_busy <= 1'b0; mvm_valid <= 1'b1; end
                else ecnt <= ecnt - 1;
            end
            if (mvm_ack) mvm_valid <= 1'b0;
        end
    end

    // update unit model: the n-th update of a run flips when n <= k
    int ucnt = 0;
    int nth0 = 0, nth1 = 0;
    logic ubusy = 1'b0, urun = 1'b0, uflip = 1'b0;
    always @(posedge clk) begin
        upd_done <= 1'b0;
        if (!rst_n) begin
            ubusy <= 1'b0; upd_flip <= 1'b0; ucnt <= 0;
        end else begin
            if (row_clear) begin nth0 <= 0; nth1 <= 0; end
            if (upd_go) begin
                ubusy <= 1'b1; ucnt <= LAT_U; urun <= upd_run;
                if (!upd_run) begin uflip <= (nth0 + 1 <= k0); nth0 <= nth0 + 1; end
                else          begin uflip <= (nth1 + 1 <= k1); nth1 <= nth1 + 1; end
            end else if (ubusy) begin
                if (ucnt == 1) begin
                    ubusy <= 1'b0; upd_done <= 1'b1; upd_flip <= uflip;
                end else ucnt <= ucnt - 1;
            end
        end
    end

    // protocol monitors
    int viol_issue = 0, viol_take = 0, viol_alt = 0, viol_order = 0, overlap = 0;
    logic have_prev = 1'b0, prev_run = 1'b0, r0_back = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mvm_go && (mvm_busy || mvm_valid)) viol_issue++;            // R3
            if (mvm_ack != upd_go) viol_take++;                             // R4
            if (upd_go && (ubusy || !mvm_valid)) viol_take++;               // R4
            if (upd_go && upd_run != erun) viol_take++;                     // R4
            if (mvm_go) begin                                               // R5
                if (have_prev && mvm_run == prev_run && !run_done[!mvm_run]) viol_alt++;
                if (run_done[mvm_run]) viol_alt++;
                have_prev = 1'b1; prev_run = mvm_run;
            end
            if (mvm_valid && !erun) r0_back = 1'b1;
            if (seed_req && !seed_run) begin r0_back = 1'b0; have_prev = 1'b0; end
            if (seed_req && seed_run && !r0_back) viol_order++;            // R2
            if (ubusy && (mvm_busy || mvm_valid) && urun != erun) overlap++; // R10
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic check_idle(input string req);
        chk(active == 0, req, "active", active, 0);
        chk(seed_req == 0 && mvm_go == 0 && upd_go == 0 && mvm_ack == 0, req,
            "handshake outputs", {seed_req, mvm_go, upd_go, mvm_ack}, 0);
        chk(run_done == 0 && run_conv == 0, req, "flags", {run_done, run_conv}, 0);
        chk(run_iter == 0, req, "iterations", run_iter, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_idle("R1");            // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");            // R1 after release

        for (int r = 0; r < ROWS; r++) begin
            int guard;
            k0 = K0[r]; k1 = K1[r];
            @(negedge clk); row_clear = 1'b1;
            @(negedge clk); row_clear = 1'b0;
            pulse_start();
            guard = 0;
            while (!seed_req && guard < 50) begin @(negedge clk); guard++; end
            chk(seed_req && seed_run == 0, "R2", "first seed is run 0", seed_run, 0);
            if (r == 1) begin
                repeat (40) @(negedge clk);
                chk(active == 1, "R9", "still running before stray start", active, 1);
                pulse_start();
                @(negedge clk);
                chk(seed_req == 0, "R9", "stray start raised seed", seed_req, 0);
            end
            guard = 0;
            while (active && guard < 5000) begin @(negedge clk); guard++; end
            chk(!active, "R8", "active falls after both runs", active, 0);
            repeat (8) @(negedge clk);
            chk(run_iter[IW-1:0] == E0[r], "R7", "run0 iterations (R6, R11)",
                run_iter[IW-1:0], E0[r]);
            chk(run_iter[2*IW-1:IW] == E1[r], "R7", "run1 iterations (R6, R11)",
                run_iter[2*IW-1:IW], E1[r]);
            chk(run_conv[0] == C0[r], "R7", "run0 converged", run_conv[0], C0[r]);
            chk(run_conv[1] == C1[r], "R7", "run1 converged", run_conv[1], C1[r]);
            chk(run_done == 2'b11, "R8", "both done flags held", run_done, 3);
            chk(nth0 == E0[r] && nth1 == E1[r], "R6", "update count per run",
                nth0 * 100 + nth1, E0[r] * 100 + E1[r]);
        end

        chk(viol_issue == 0, "R3", "issue while engine occupied", viol_issue, 0);
        chk(viol_take == 0, "R4", "take/update pairing", viol_take, 0);
        chk(viol_alt == 0, "R5", "alternation breaks", viol_alt, 0);
        chk(viol_order == 0, "R2", "run1 seeded early", viol_order, 0);
        chk(overlap > 0, "R10", "update overlapped other product", overlap > 0, 1);

        // reset in the middle of a run
        k0 = 30; k1 = 30;
        @(negedge clk); row_clear = 1'b1;
        @(negedge clk); row_clear = 1'b0;
        pulse_start();
        repeat (60) @(negedge clk);
        chk(active == 1 && run_iter != 0, "R1", "run in progress before reset",
            active, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule